// File: doc/BRIEF.md
# Lock-Aware Way Replacement Selector

This block makes the locking and eviction decisions for one index of an 8-way set-associative cache. Several agents share the cache. Each agent has its own way-usage mask, which limits the ways it may allocate into. For every request the caller supplies the index, the lock bits and valid bits currently stored at that index, and the requesting agent's mask. The block answers one cycle later. A lock request returns an updated lock vector. A miss request returns a victim way, plus a lock vector with any forced unlock applied. The caller writes the returned lock vector back into its tag storage.

Locking is protected so that every agent always keeps at least one way it can replace into. A lock that would use up the last unlocked way in the agent's mask is not applied. The response is still returned, so the load carrying the lock completes. A sticky lock-refusal flag is set. Another agent can still lock every way in a mask. If a miss then finds no unlocked way in its mask, the block takes the lowest way of the mask anyway, unlocks it, and sets a second sticky flag. Each flag has its own interrupt enable. Software clears a flag by pulsing its clear input. The index of the latest error is kept for debug.

Normal victim choice is as follows. The lowest-numbered way that is invalid, unlocked and allowed is taken first. Otherwise a per-index round-robin pointer scans the unlocked allowed ways.

Top module: `lockaware_victim_sel`

## Requirements
- R1: A miss that has at least one unlocked way in its effective mask never returns a locked way as victim.
- R2: The effective mask is the requester mask, or all ways when the requester mask is zero. Every victim lies inside the effective mask.
- R3: A lock request (`req_op`=1) on way W is granted only if some way other than W stays unlocked within the effective mask. If granted, the returned lock vector is the input with bit W set. If refused, the returned lock vector equals the input and `lock_err` is set.
- R4: A refused lock still produces a response: `rsp_valid`=1, `rsp_op`=1, `rsp_way`=W and `rsp_grant`=0.
- R5: A miss (`req_op`=0) whose effective mask is entirely locked returns the lowest-numbered way of the effective mask. The returned lock vector has that way's bit cleared, `rsp_forced`=1 and `evict_err` is set.
- R6: `lock_irq` equals `lock_err` AND `lock_irq_en`. `evict_irq` equals `evict_err` AND `evict_irq_en`.
- R7: Both error flags stay set until their clear input is high at a clock edge. If a new error and the clear of that flag arrive in the same cycle, the flag remains set.
- R8: `err_index` holds the index of the most recent request that set either error flag.
- R9: A non-forced miss returns the lowest-numbered way that is unlocked, allowed and invalid. If there is none, it returns the first unlocked allowed way at or after the round-robin pointer of that index, scanning upward with wrap. Only in that round-robin case does the pointer move to the victim plus one, modulo 8. All pointers reset to 0.
- R10: Responses appear on the clock edge after the request and `rsp_valid` is 0 when no request was presented. After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 1 = lock request, 0 = miss replacement |
| req_index | input | IDX_W | Cache index of the request |
| req_way | input | WAY_W | Way to lock (lock requests only) |
| req_locks | input | WAYS | Current lock bits at the index |
| req_valids | input | WAYS | Current valid bits at the index |
| req_mask | input | WAYS | Requester way-usage mask (zero = all ways) |
| clr_lock_err | input | 1 | Clear pulse for the lock-refusal flag |
| clr_evict_err | input | 1 | Clear pulse for the forced-eviction flag |
| lock_irq_en | input | 1 | Interrupt enable for the lock-refusal flag |
| evict_irq_en | input | 1 | Interrupt enable for the forced-eviction flag |
| rsp_valid | output | 1 | Response present |
| rsp_op | output | 1 | Operation of the response |
| rsp_way | output | WAY_W | Victim way (miss) or target way (lock) |
| rsp_locks | output | WAYS | Lock vector to write back |
| rsp_grant | output | 1 | Lock applied |
| rsp_forced | output | 1 | Victim was taken from a fully locked mask |
| lock_err | output | 1 | Sticky lock-refusal flag |
| evict_err | output | 1 | Sticky forced-eviction flag |
| err_index | output | IDX_W | Index of the latest error |
| lock_irq | output | 1 | Masked lock-refusal interrupt |
| evict_irq | output | 1 | Masked forced-eviction interrupt |

## Verification
Two things can fall in the same cycle: raising an error flag from a request, and software clearing that same flag. The bench first lets a refused lock set the flag. It then presents a second refused lock in the same cycle as the clear pulse, and checks that the flag is still high afterwards. In a separate cycle it checks that a clear with no error drops the flag. The sweeps also mix refused locks and forced evictions at changing indices, and check after each one that `err_index` follows the latest error.

// File: rtl/lvs_pkg.sv
package lvs_pkg;

    typedef enum logic {
        OP_MISS = 1'b0,
        OP_LOCK = 1'b1
    } lvs_op_e;

endpackage

// File: rtl/lvs_lock_gate.sv
// Decides whether a lock may be applied without exhausting the requester's ways.
module lvs_lock_gate #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  eff_mask,
    input  logic [WAYS-1:0]  locks_in,
    input  logic [WAY_W-1:0] tgt_way,
    output logic             grant,
    output logic [WAYS-1:0]  locks_out
);

    logic [WAYS-1:0] tgt_onehot;
    logic [WAYS-1:0] spare;

    always_comb begin
        tgt_onehot          = '0;
        tgt_onehot[tgt_way] = 1'b1;
        // ways that would still be free for this requester after the lock
        spare               = eff_mask & ~locks_in & ~tgt_onehot;
        grant               = |spare;
        locks_out           = grant ? (locks_in | tgt_onehot) : locks_in;
    end

endmodule

// File: rtl/lvs_victim_pick.sv
// Victim choice for one miss: invalid first, then round-robin, forced as last resort.
module lvs_victim_pick #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  eff_mask,
    input  logic [WAYS-1:0]  locks_in,
    input  logic [WAYS-1:0]  valids_in,
    input  logic [WAY_W-1:0] rr_ptr,
    output logic [WAY_W-1:0] victim,
    output logic             forced,
    output logic             used_rr,
    output logic [WAYS-1:0]  locks_out
);

    logic [WAYS-1:0]  cand;
    logic [WAYS-1:0]  invalid_cand;
    logic [WAY_W-1:0] low_mask_way;
    logic [WAY_W-1:0] low_inv_way;
    logic [WAY_W-1:0] rr_way;
    logic             rr_found;

    always_comb begin
        cand         = eff_mask & ~locks_in;
        invalid_cand = cand & ~valids_in;

        // lowest set bit: scan downward so the last hit is the lowest
        low_mask_way = '0;
        low_inv_way  = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (eff_mask[i])     low_mask_way = WAY_W'(i);
            if (invalid_cand[i]) low_inv_way  = WAY_W'(i);
        end

        // first candidate at or after the pointer, wrapping
        rr_way   = '0;
        rr_found = 1'b0;
        for (int k = 0; k < WAYS; k++) begin
            int pos;
            pos = (int'(rr_ptr) + k) % WAYS;
            if (!rr_found && cand[pos]) begin
                rr_way   = WAY_W'(pos);
                rr_found = 1'b1;
            end
        end

        forced    = (cand == '0);
        used_rr   = 1'b0;
        locks_out = locks_in;
        if (forced) begin
            victim                  = low_mask_way;
            locks_out[low_mask_way] = 1'b0;
        end else if (invalid_cand != '0) begin
            victim = low_inv_way;
        end else begin
            victim  = rr_way;
            used_rr = 1'b1;
        end
    end

endmodule

// File: rtl/lvs_rr_ptrs.sv
// One round-robin pointer per cache index.
module lvs_rr_ptrs #(
    parameter int WAYS  = 8,
    parameter int IDX_W = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WAY_W-1:0] rd_ptr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WAY_W-1:0] wr_ptr
);

    localparam int NUM_IDX = 1 << IDX_W;

    logic [WAY_W-1:0] ptr_q_all [NUM_IDX];

    for (genvar g = 0; g < NUM_IDX; g++) begin : g_ent
        logic [WAY_W-1:0] ent_d;
        logic [WAY_W-1:0] ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == IDX_W'(g))) ent_d = wr_ptr;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign ptr_q_all[g] = ent_q;
    end

    assign rd_ptr = ptr_q_all[rd_idx];

endmodule

// File: rtl/lockaware_victim_sel.sv
module lockaware_victim_sel
    import lvs_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int IDX_W = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_op,
    input  logic [IDX_W-1:0] req_index,
    input  logic [WAY_W-1:0] req_way,
    input  logic [WAYS-1:0]  req_locks,
    input  logic [WAYS-1:0]  req_valids,
    input  logic [WAYS-1:0]  req_mask,
    input  logic             clr_lock_err,
    input  logic             clr_evict_err,
    input  logic             lock_irq_en,
    input  logic             evict_irq_en,
    output logic             rsp_valid,
    output logic             rsp_op,
    output logic [WAY_W-1:0] rsp_way,
    output logic [WAYS-1:0]  rsp_locks,
    output logic             rsp_grant,
    output logic             rsp_forced,
    output logic             lock_err,
    output logic             evict_err,
    output logic [IDX_W-1:0] err_index,
    output logic             lock_irq,
    output logic             evict_irq
);

    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    typedef struct packed {
        logic             rsp_valid;
        logic             rsp_op;
        logic [WAY_W-1:0] rsp_way;
        logic [WAYS-1:0]  rsp_locks;
        logic             rsp_grant;
        logic             rsp_forced;
        logic             lock_err;
        logic             evict_err;
        logic [IDX_W-1:0] err_index;
    } state_t;

    state_t st_d, st_q;

    lvs_op_e          op;
    logic [WAYS-1:0]  eff_mask;
    logic             lk_grant;
    logic [WAYS-1:0]  lk_locks;
    logic [WAY_W-1:0] rr_ptr;
    logic [WAY_W-1:0] mv_way;
    logic             mv_forced;
    logic             mv_used_rr;
    logic [WAYS-1:0]  mv_locks;
    logic             rr_we;
    logic [WAY_W-1:0] rr_next;

    assign op       = lvs_op_e'(req_op);
    assign eff_mask = (req_mask == '0) ? '1 : req_mask;

    lvs_lock_gate #(.WAYS(WAYS), .WAY_W(WAY_W)) lock_gate_i (
        .eff_mask  (eff_mask),
        .locks_in  (req_locks),
        .tgt_way   (req_way),
        .grant     (lk_grant),
        .locks_out (lk_locks)
    );

    lvs_victim_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) victim_pick_i (
        .eff_mask  (eff_mask),
        .locks_in  (req_locks),
        .valids_in (req_valids),
        .rr_ptr    (rr_ptr),
        .victim    (mv_way),
        .forced    (mv_forced),
        .used_rr   (mv_used_rr),
        .locks_out (mv_locks)
    );

    assign rr_we   = req_valid && (op == OP_MISS) && mv_used_rr;
    assign rr_next = (mv_way == LAST_WAY) ? '0 : mv_way + WAY_W'(1);

    lvs_rr_ptrs #(.WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) rr_ptrs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (req_index),
        .rd_ptr (rr_ptr),
        .wr_en  (rr_we),
        .wr_idx (req_index),
        .wr_ptr (rr_next)
    );

    always_comb begin
        logic lock_hit;
        logic evict_hit;

        st_d            = st_q;
        st_d.rsp_valid  = req_valid;
        st_d.rsp_op     = 1'b0;
        st_d.rsp_way    = '0;
        st_d.rsp_locks  = '0;
        st_d.rsp_grant  = 1'b0;
        st_d.rsp_forced = 1'b0;
        lock_hit        = 1'b0;
        evict_hit       = 1'b0;

        if (req_valid) begin
            st_d.rsp_op = req_op;
            if (op == OP_LOCK) begin
                st_d.rsp_way   = req_way;
                st_d.rsp_locks = lk_locks;
                st_d.rsp_grant = lk_grant;
                lock_hit       = !lk_grant;
            end else begin
                st_d.rsp_way    = mv_way;
                st_d.rsp_locks  = mv_locks;
                st_d.rsp_forced = mv_forced;
                evict_hit       = mv_forced;
            end
        end

        // a fresh error outranks a clear in the same cycle
        st_d.lock_err  = (st_q.lock_err  & ~clr_lock_err)  | lock_hit;
        st_d.evict_err = (st_q.evict_err & ~clr_evict_err) | evict_hit;
        if (lock_hit || evict_hit) st_d.err_index = req_index;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_op     = st_q.rsp_op;
    assign rsp_way    = st_q.rsp_way;
    assign rsp_locks  = st_q.rsp_locks;
    assign rsp_grant  = st_q.rsp_grant;
    assign rsp_forced = st_q.rsp_forced;
    assign lock_err   = st_q.lock_err;
    assign evict_err  = st_q.evict_err;
    assign err_index  = st_q.err_index;
    assign lock_irq   = st_q.lock_err  & lock_irq_en;
    assign evict_irq  = st_q.evict_err & evict_irq_en;

endmodule

// File: rtl/lvs_checker.sv
module lvs_checker #(
    parameter int WAYS  = 8,
    parameter int IDX_W = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_op,
    input logic [WAYS-1:0]  req_locks,
    input logic [WAYS-1:0]  req_mask,
    input logic             clr_lock_err,
    input logic             clr_evict_err,
    input logic             rsp_valid,
    input logic             rsp_op,
    input logic [WAY_W-1:0] rsp_way,
    input logic [WAYS-1:0]  rsp_locks,
    input logic             rsp_grant,
    input logic             rsp_forced,
    input logic             lock_err,
    input logic             evict_err,
    input logic             lock_irq,
    input logic             evict_irq
);

    logic [WAYS-1:0] seen_mask_q;
    logic [WAYS-1:0] seen_locks_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_mask_q  <= '1;
            seen_locks_q <= '0;
        end else if (req_valid) begin
            seen_mask_q  <= (req_mask == '0) ? '1 : req_mask;
            seen_locks_q <= req_locks;
        end
    end

    AST_NO_LOCKED_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_op && !rsp_forced) |-> !seen_locks_q[rsp_way]); // R1
    AST_VICTIM_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_op) |-> seen_mask_q[rsp_way]); // R2
    AST_GRANT_LEAVES_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_op && rsp_grant) |-> ((seen_mask_q & ~rsp_locks) != '0)); // R3
    AST_REFUSE_KEEPS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_op && !rsp_grant) |-> (rsp_locks == seen_locks_q && lock_err)); // R3
    AST_FORCED_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_forced |-> (!rsp_locks[rsp_way] && evict_err)); // R5
    AST_LOCK_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        lock_irq |-> lock_err); // R6
    AST_EVICT_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        evict_irq |-> evict_err); // R6
    AST_LOCK_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock_err) && !$past(clr_lock_err)) |-> lock_err); // R7
    AST_EVICT_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(evict_err) && !$past(clr_evict_err)) |-> evict_err); // R7
    AST_LOCK_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_err) |-> (rsp_valid && rsp_op && !rsp_grant)); // R3

endmodule

bind lockaware_victim_sel lvs_checker #(.WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)) chk_i (.*);

// File: tb/lockaware_victim_sel_tb_top.sv
module lockaware_victim_sel_tb_top;

    localparam int WAYS  = 8;
    localparam int IDX_W = 4;
    localparam int WAY_W = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid, req_op;
    logic [IDX_W-1:0] req_index;
    logic [WAY_W-1:0] req_way;
    logic [WAYS-1:0]  req_locks, req_valids, req_mask;
    logic             clr_lock_err, clr_evict_err, lock_irq_en, evict_irq_en;
    logic             rsp_valid, rsp_op, rsp_grant, rsp_forced;
    logic [WAY_W-1:0] rsp_way;
    logic [WAYS-1:0]  rsp_locks;
    logic             lock_err, evict_err, lock_irq, evict_irq;
    logic [IDX_W-1:0] err_index;

    int tests = 0;
    int fails = 0;
    int rr_model [16];

    always #10 clk = ~clk;

    lockaware_victim_sel #(.WAYS(WAYS), .IDX_W(IDX_W)) dut_i (.*);

    task automatic check(bit ok, string req, logic [31:0] got, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic issue(bit op, int idx, int way, logic [7:0] locks, logic [7:0] valids, logic [7:0] mask);
        req_valid  = 1'b1;
        req_op     = op;
        req_index  = IDX_W'(idx);
        req_way    = WAY_W'(way);
        req_locks  = locks;
        req_valids = valids;
        req_mask   = mask;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    function automatic int lowest(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic logic [7:0] pattern(int m, int li);
        logic [7:0] e;
        e = (m == 0) ? 8'hFF : 8'(m);
        if (li == 15) return 8'hFF;
        if (li == 14) return e;
        if (li == 13) return e & (e - 8'd1);
        return 8'((li * 45 + m * 19) & 255);
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 0; req_op = 0; req_index = 0; req_way = 0;
        req_locks = 0; req_valids = 0; req_mask = 0;
        clr_lock_err = 0; clr_evict_err = 0; lock_irq_en = 0; evict_irq_en = 0;
        for (int i = 0; i < 16; i++) rr_model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check({rsp_valid, rsp_op, rsp_way, rsp_locks, rsp_grant, rsp_forced, lock_err, evict_err, err_index} == '0,
              "R10 reset outputs", {rsp_valid, rsp_locks, lock_err, evict_err}, 0);

        // lock sweep: R3, R4, R8
        for (int m = 0; m < 256; m++) begin
            for (int li = 0; li < 16; li++) begin
                for (int w = 0; w < 8; w++) begin
                    logic [7:0] e, lk, tgt, exp_l;
                    bit g;
                    int idx;
                    e     = (m == 0) ? 8'hFF : 8'(m);
                    lk    = pattern(m, li);
                    tgt   = 8'(1 << w);
                    g     = ((e & ~lk & ~tgt) != 0);
                    exp_l = g ? (lk | tgt) : lk;
                    idx   = (m + li + w) & 15;
                    issue(1'b1, idx, w, lk, 8'hFF, 8'(m));
                    check(rsp_grant == g && rsp_locks == exp_l, "R3 lock decision",
                          {rsp_grant, rsp_locks}, {g, exp_l});
                    check(rsp_valid && rsp_op && rsp_way == WAY_W'(w), "R4 lock response",
                          {rsp_valid, rsp_op, rsp_way}, {1'b1, 1'b1, 3'(w)});
                    if (!g) check(lock_err && err_index == IDX_W'(idx), "R8 lock error index",
                                  {lock_err, err_index}, {1'b1, 4'(idx)});
                end
            end
        end

        // miss sweep: R1, R2, R5, R9
        for (int m = 0; m < 256; m++) begin
            for (int li = 0; li < 16; li++) begin
                for (int vi = 0; vi < 4; vi++) begin
                    logic [7:0] e, lk, vl, cand, inv, exp_l;
                    int v, idx;
                    bit frc;
                    e    = (m == 0) ? 8'hFF : 8'(m);
                    lk   = pattern(m, li);
                    vl   = (vi == 0) ? 8'hFF : (vi == 1) ? 8'h00 : (vi == 2) ? 8'hA5 : 8'h0F;
                    idx  = (m ^ li) & 15;
                    cand = e & ~lk;
                    inv  = cand & ~vl;
                    exp_l = lk;
                    frc  = (cand == 0);
                    if (frc) begin
                        v = lowest(e);
                        exp_l[v] = 1'b0;
                    end else if (inv != 0) begin
                        v = lowest(inv);
                    end else begin
                        v = 0;
                        for (int k = 7; k >= 0; k--)
                            if (cand[(rr_model[idx] + k) % 8]) v = (rr_model[idx] + k) % 8;
                        rr_model[idx] = (v + 1) % 8;
                    end
                    issue(1'b0, idx, 0, lk, vl, 8'(m));
                    if (frc) begin
                        check(rsp_forced && rsp_way == WAY_W'(v) && rsp_locks == exp_l && evict_err &&
                              err_index == IDX_W'(idx), "R5 forced eviction",
                              {rsp_forced, rsp_way, rsp_locks}, {1'b1, 3'(v), exp_l});
                    end else begin
                        check(!rsp_forced && rsp_way == WAY_W'(v) && rsp_locks == lk, "R9 victim choice",
                              {rsp_forced, rsp_way, rsp_locks}, {1'b0, 3'(v), lk});
                        check(!lk[rsp_way], "R1 victim unlocked", {29'd0, rsp_way}, 32'(v));
                        check(e[rsp_way] && rsp_valid && !rsp_op, "R2 victim in mask",
                              {rsp_valid, rsp_op, rsp_way}, {1'b1, 1'b0, 3'(v)});
                    end
                end
            end
        end

        // R7: clear both flags, then idle response
        clr_lock_err = 1; clr_evict_err = 1;
        @(negedge clk);
        clr_lock_err = 0; clr_evict_err = 0;
        check(!lock_err && !evict_err, "R7 clear flags", {lock_err, evict_err}, 0);
        check(!rsp_valid, "R10 idle no response", rsp_valid, 0);

        // refused lock at index 5
        issue(1'b1, 5, 0, 8'h00, 8'hFF, 8'h01);
        check(lock_err && err_index == 4'd5, "R8 lock error index", {lock_err, err_index}, {1'b1, 4'd5});
        #1;
        check(!lock_irq, "R6 lock irq disabled", lock_irq, 0);
        lock_irq_en = 1; #1;
        check(lock_irq, "R6 lock irq enabled", lock_irq, 1);

        // idle cycles keep the flag (R7)
        repeat (3) @(negedge clk);
        check(lock_err, "R7 flag sticky", lock_err, 1);

        // new refusal with clear in the same cycle: flag stays
        clr_lock_err = 1;
        issue(1'b1, 2, 0, 8'h00, 8'hFF, 8'h01);
        clr_lock_err = 0;
        check(lock_err && err_index == 4'd2, "R7 set wins over clear", {lock_err, err_index}, {1'b1, 4'd2});

        // forced eviction at index 9
        issue(1'b0, 9, 0, 8'hFF, 8'hFF, 8'h0C);
        check(rsp_forced && rsp_way == 3'd2 && rsp_locks == 8'hFB, "R5 forced lowest allowed",
              {rsp_way, rsp_locks}, {3'd2, 8'hFB});
        check(evict_err && err_index == 4'd9, "R8 evict error index", {evict_err, err_index}, {1'b1, 4'd9});
        #1;
        check(!evict_irq && lock_irq, "R6 evict irq disabled", {evict_irq, lock_irq}, 1);
        evict_irq_en = 1; #1;
        check(evict_irq, "R6 evict irq enabled", evict_irq, 1);

        // clear without a new error drops the flag
        clr_lock_err = 1;
        @(negedge clk);
        clr_lock_err = 0;
        check(!lock_err && !lock_irq && evict_err, "R7 clear one flag", {lock_err, evict_err}, 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule